// File: doc/BRIEF.md
# Mode-Selected Window/Timeout Watchdog

This block supervises software with a tick-driven counter whose behaviour is picked automatically from three things: the chip's power-mode code, a mode-control bit (`mode_ctl`) and a hardware disable pin (`wd_disable`). The watchdog has three states:

- **ST_OFF**: the counter is held at zero.
- **ST_TIMEOUT**: a software kick at any time restarts the count.
- **ST_WINDOW**: a kick is legal only in the open second half of the period. An early kick or a missed period asks for a system reset.

In ST_TIMEOUT, a first overflow raises a cyclic interrupt and sets a pending flag. A second overflow while that flag is still set escalates to a reset request. Software clears the flag by pulsing `ci_ack`.

The state machine has three named transitions, each evaluated every clock:

- **T_DISABLE**: any state goes to ST_OFF.
- **T_ARM_TIMEOUT**: any state goes to ST_TIMEOUT.
- **T_ARM_WINDOW**: any state goes to ST_WINDOW.

Whenever the target differs from the present state, the transition fires. In that cycle the counter restarts from zero and any kick or tick is dropped. Request outputs are registered one-cycle pulses, raised on the clock edge after the event.

Top module: `cyc_watchdog`

## Requirements
- R1: While `wd_disable` is 1 the watchdog is in ST_OFF in every power mode, and no request pulse appears.
- R2: Power-mode codes are 0 = Off, 1 = Standby, 2 = Normal, 3 = Sleep, 4 = Overtemp. With `wd_disable` = 0, the watchdog is in ST_OFF in the following cases, with no requests:
  - codes 0, 3 or 4;
  - codes 1 or 2 with `mode_ctl` = 0.
- R3: Code 1 with `mode_ctl` = 1 selects ST_TIMEOUT. A kick at any count restarts the counter. The P-th tick without a kick is an overflow.
- R4: Code 2 with `mode_ctl` = 1 selects ST_WINDOW. A kick while the count (ticks since restart) is at least P/2 restarts the counter with no request.
- R5: A ST_TIMEOUT overflow with `ci_pend` = 0 gives a one-cycle `ci_req` pulse on the next clock edge and sets `ci_pend` at that same edge.
- R6: A ST_TIMEOUT overflow with `ci_pend` = 1 gives a one-cycle `rst_req` with `rst_cause` = 3 (escalation).
- R7: A ST_WINDOW overflow (P ticks without a kick) gives `rst_req` with `rst_cause` = 1 (late).
- R8: A kick in ST_WINDOW while the count is below P/2 gives `rst_req` with `rst_cause` = 2 (early) and restarts the counter.
- R9: Any state transition restarts the count from zero. In ST_OFF the count stays zero.
- R10: A 1 on `ci_ack` clears `ci_pend` at the next edge, unless a new interrupt is raised at that same edge. Setting wins over clearing.
- R11: A `period` value below 2 behaves as P = 2.
- R12: `rst_cause` is 0 whenever `rst_req` is 0, and `ci_req` and `rst_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_mode | input | 3 | Power-mode code (see R2) |
| mode_ctl | input | 1 | Mode-control bit enabling the watchdog |
| wd_disable | input | 1 | Hardware disable pin level |
| kick | input | 1 | Software trigger strobe, one cycle |
| period | input | CW | Period P in ticks |
| tick | input | 1 | Time-base strobe, one cycle |
| ci_ack | input | 1 | Write-one-to-clear for `ci_pend` |
| ci_req | output | 1 | Cyclic-interrupt request pulse |
| ci_pend | output | 1 | Cyclic-interrupt pending flag |
| rst_req | output | 1 | Reset request pulse |
| rst_cause | output | 2 | Reset cause: 1 late, 2 early, 3 escalation |

## Verification
The hardest state to reach from the ports is the timeout escalation. It needs two full periods without a kick and with no acknowledge in between, and each period is measured in ticks rather than clocks.

The stimulus first proves that kicks hold off the interrupt. It then stops kicking long enough for one interrupt, keeps `ci_ack` low, and runs one more period.

A transition restart in mid-count is also hard to reach. The stimulus drops `mode_ctl` for a single clock after three ticks. It then shows that three further ticks are not enough to overflow but a fourth is.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [2:0] {
        PM_OFF      = 3'd0,
        PM_STANDBY  = 3'd1,
        PM_NORMAL   = 3'd2,
        PM_SLEEP    = 3'd3,
        PM_OVERTEMP = 3'd4
    } pwr_mode_e;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_TIMEOUT = 2'd1,
        ST_WINDOW  = 2'd2
    } wd_state_e;

    typedef enum logic [1:0] {
        RC_NONE     = 2'd0,
        RC_LATE     = 2'd1,
        RC_EARLY    = 2'd2,
        RC_ESCALATE = 2'd3
    } rst_cause_e;

    typedef struct packed {
        logic at_limit;
        logic in_closed;
    } cnt_stat_t;

endpackage

// File: rtl/wdg_mode_sel.sv
module wdg_mode_sel
    import wdg_pkg::*;
(
    input  logic [2:0] pwr_mode,
    input  logic       mode_ctl,
    input  logic       wd_disable,
    output wd_state_e  target
);

    always_comb begin
        target = ST_OFF;
        if (!wd_disable && mode_ctl) begin
            unique case (pwr_mode)
                PM_STANDBY: target = ST_TIMEOUT;
                PM_NORMAL:  target = ST_WINDOW;
                default:    target = ST_OFF;
            endcase
        end
    end

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [CW-1:0] period,
    output cnt_stat_t     stat
);

    localparam logic [CW-1:0] MIN_P = CW'(2);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] eff_p;
    logic [CW-1:0] half_p;

    always_comb begin
        eff_p  = (period < MIN_P) ? MIN_P : period;
        half_p = eff_p >> 1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    always_comb begin
        stat.at_limit  = (cnt_q == eff_p - CW'(1));
        stat.in_closed = (cnt_q < half_p);
    end

endmodule

// File: rtl/wdg_fsm.sv
module wdg_fsm
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  wd_state_e  target,
    input  logic       kick,
    input  logic       tick,
    input  logic       ci_ack,
    input  cnt_stat_t  stat,
    output logic       cnt_clear,
    output logic       ci_req,
    output logic       ci_pend,
    output logic       rst_req,
    output logic [1:0] rst_cause
);

    wd_state_e  state_q;
    logic       ci_fire;
    logic       rst_fire;
    rst_cause_e cause_d;
    logic       transition;

    // State register: the target is re-evaluated on every clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= target;
        end
    end

    assign transition = (target != state_q);

    // Output decode for the present state.
    always_comb begin
        cnt_clear = 1'b0;
        ci_fire   = 1'b0;
        rst_fire  = 1'b0;
        cause_d   = RC_NONE;
        if (transition) begin
            cnt_clear = 1'b1;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    cnt_clear = 1'b1;
                end
                ST_TIMEOUT: begin
                    if (kick) begin
                        cnt_clear = 1'b1;
                    end else if (tick && stat.at_limit) begin
                        cnt_clear = 1'b1;
                        if (ci_pend) begin
                            rst_fire = 1'b1;
                            cause_d  = RC_ESCALATE;
                        end else begin
                            ci_fire = 1'b1;
                        end
                    end
                end
                ST_WINDOW: begin
                    if (kick) begin
                        cnt_clear = 1'b1;
                        if (stat.in_closed) begin
                            rst_fire = 1'b1;
                            cause_d  = RC_EARLY;
                        end
                    end else if (tick && stat.at_limit) begin
                        cnt_clear = 1'b1;
                        rst_fire  = 1'b1;
                        cause_d   = RC_LATE;
                    end
                end
                default: begin
                    cnt_clear = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ci_req    <= 1'b0;
            ci_pend   <= 1'b0;
            rst_req   <= 1'b0;
            rst_cause <= RC_NONE;
        end else begin
            ci_req    <= ci_fire;
            ci_pend   <= (ci_pend & ~ci_ack) | ci_fire;
            rst_req   <= rst_fire;
            rst_cause <= rst_fire ? cause_d : RC_NONE;
        end
    end

endmodule

// File: rtl/cyc_watchdog.sv
module cyc_watchdog
    import wdg_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    pwr_mode,
    input  logic          mode_ctl,
    input  logic          wd_disable,
    input  logic          kick,
    input  logic [CW-1:0] period,
    input  logic          tick,
    input  logic          ci_ack,
    output logic          ci_req,
    output logic          ci_pend,
    output logic          rst_req,
    output logic [1:0]    rst_cause
);

    wd_state_e target;
    cnt_stat_t stat;
    logic      cnt_clear;

    wdg_mode_sel u_sel (
        .pwr_mode   (pwr_mode),
        .mode_ctl   (mode_ctl),
        .wd_disable (wd_disable),
        .target     (target)
    );

    wdg_counter #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cnt_clear),
        .tick   (tick),
        .period (period),
        .stat   (stat)
    );

    wdg_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .target    (target),
        .kick      (kick),
        .tick      (tick),
        .ci_ack    (ci_ack),
        .stat      (stat),
        .cnt_clear (cnt_clear),
        .ci_req    (ci_req),
        .ci_pend   (ci_pend),
        .rst_req   (rst_req),
        .rst_cause (rst_cause)
    );

endmodule

// File: rtl/cyc_watchdog_chk.sv
module cyc_watchdog_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] pwr_mode,
    input logic       mode_ctl,
    input logic       wd_disable,
    input logic       ci_ack,
    input logic       ci_req,
    input logic       ci_pend,
    input logic       rst_req,
    input logic [1:0] rst_cause
);

    p_disable_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wd_disable |=> (!ci_req && !rst_req));

    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_ctl || (pwr_mode != 3'd1 && pwr_mode != 3'd2)) |=> (!ci_req && !rst_req));

    p_ci_sets_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ci_req |-> (ci_pend && !$past(ci_pend)));

    p_escalate_needs_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && rst_cause == 2'd3) |-> $past(ci_pend));

    p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ci_ack |=> (ci_req || !ci_pend));

    p_cause_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req |-> (rst_cause == 2'd0));

    p_cause_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (rst_cause != 2'd0));

    p_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ci_req && rst_req));

endmodule

bind cyc_watchdog cyc_watchdog_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_mode   (pwr_mode),
    .mode_ctl   (mode_ctl),
    .wd_disable (wd_disable),
    .ci_ack     (ci_ack),
    .ci_req     (ci_req),
    .ci_pend    (ci_pend),
    .rst_req    (rst_req),
    .rst_cause  (rst_cause)
);

// File: tb/cyc_watchdog_test.sv
`timescale 1ns/1ps
module cyc_watchdog_test;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    pwr_mode = 3'd0;
    logic          mode_ctl = 1'b0;
    logic          wd_disable = 1'b0;
    logic          kick = 1'b0;
    logic [CW-1:0] period = 16'd4;
    logic          tick = 1'b0;
    logic          ci_ack = 1'b0;
    logic          ci_req;
    logic          ci_pend;
    logic          rst_req;
    logic [1:0]    rst_cause;

    int checks = 0;
    int errors = 0;
    int ev_ci = 0, ev_late = 0, ev_early = 0, ev_esc = 0;
    int cycles = 0;

    // reference model state
    int m_mode = 0, m_cnt = 0;
    bit m_pend = 0, m_ci = 0, m_rst = 0;
    int m_cause = 0;

    always #2.5 clk = ~clk;

    cyc_watchdog #(.CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode), .mode_ctl(mode_ctl),
        .wd_disable(wd_disable), .kick(kick), .period(period), .tick(tick),
        .ci_ack(ci_ack), .ci_req(ci_req), .ci_pend(ci_pend),
        .rst_req(rst_req), .rst_cause(rst_cause)
    );

    // Behavioural model, advanced on each rising edge.
    always @(posedge clk) begin
        int dec, eff;
        bit fci, frst;
        int fc;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_pend = 0; m_ci = 0; m_rst = 0; m_cause = 0;
        end else begin
            dec = 0;
            if (!wd_disable && mode_ctl && pwr_mode == 3'd1) dec = 1;
            if (!wd_disable && mode_ctl && pwr_mode == 3'd2) dec = 2;
            eff = (period < 2) ? 2 : int'(period);
            fci = 0; frst = 0; fc = 0;
            if (dec != m_mode) begin
                m_mode = dec;
                m_cnt = 0;
            end else if (m_mode == 1) begin
                if (kick) m_cnt = 0;
                else if (tick) begin
                    if (m_cnt == eff - 1) begin
                        m_cnt = 0;
                        if (m_pend) begin frst = 1; fc = 3; end
                        else fci = 1;
                    end else m_cnt++;
                end
            end else if (m_mode == 2) begin
                if (kick) begin
                    if (m_cnt < eff / 2) begin frst = 1; fc = 2; end
                    m_cnt = 0;
                end else if (tick) begin
                    if (m_cnt == eff - 1) begin
                        m_cnt = 0; frst = 1; fc = 1;
                    end else m_cnt++;
                end
            end else begin
                m_cnt = 0;
            end
            m_pend = (m_pend && !ci_ack) || fci;
            m_ci = fci; m_rst = frst; m_cause = fc;
        end
    end

    function automatic string cause_tag(int c);
        if (c == 1) return "R7";
        if (c == 2) return "R8";
        if (c == 3) return "R6";
        return "R12";
    endfunction

    // Per-cycle comparison and event counting, away from the rising edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            checks++;
            if (ci_req !== m_ci) begin
                errors++;
                $display("FAIL R5 ci_req act=%0b exp=%0b t=%0t", ci_req, m_ci, $time);
            end
            checks++;
            if (ci_pend !== m_pend) begin
                errors++;
                $display("FAIL R10 ci_pend act=%0b exp=%0b t=%0t", ci_pend, m_pend, $time);
            end
            checks++;
            if (rst_req !== m_rst || int'(rst_cause) != m_cause) begin
                errors++;
                $display("FAIL %s rst_req/cause act=%0b/%0d exp=%0b/%0d t=%0t",
                         cause_tag(m_cause), rst_req, rst_cause, m_rst, m_cause, $time);
            end
            if (ci_req) ev_ci++;
            if (rst_req && rst_cause == 2'd1) ev_late++;
            if (rst_req && rst_cause == 2'd2) ev_early++;
            if (rst_req && rst_cause == 2'd3) ev_esc++;
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic do_kick();
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
    endtask

    task automatic settle();
        idle(3);
        #1;
    endtask

    initial begin
        int c0;
        idle(3);
        #1;
        chk("R12 reset ci_req", int'(ci_req), 0);
        chk("R12 reset rst_req", int'(rst_req), 0);
        chk("R10 reset ci_pend", int'(ci_pend), 0);
        @(negedge clk); rst_n = 1'b1;

        // R1: disable pin overrides Normal with mode_ctl set
        wd_disable = 1'b1; pwr_mode = 3'd2; mode_ctl = 1'b1; period = 16'd4;
        ticks(12); do_kick(); settle();
        chk("R1 no reset while disabled", ev_late + ev_early + ev_esc, 0);

        // R2: Standby with mode_ctl=0, then Sleep and Overtemp
        @(negedge clk); wd_disable = 1'b0; pwr_mode = 3'd1; mode_ctl = 1'b0;
        ticks(10); do_kick();
        @(negedge clk); pwr_mode = 3'd3; mode_ctl = 1'b1;
        ticks(10); do_kick();
        @(negedge clk); pwr_mode = 3'd4;
        ticks(10); do_kick(); settle();
        chk("R2 no requests in off states", ev_ci + ev_late + ev_early + ev_esc, 0);

        // R3: Timeout, kicks hold off overflow
        @(negedge clk); pwr_mode = 3'd1; period = 16'd4;
        idle(2);
        for (int k = 0; k < 5; k++) begin ticks(3); do_kick(); end
        settle();
        chk("R3 kicks restart timeout", ev_ci, 0);

        // R5: first overflow raises interrupt
        ticks(4); settle();
        chk("R5 interrupt after overflow", ev_ci, 1);
        chk("R5 pending set", int'(ci_pend), 1);

        // R6: second overflow with pending escalates
        ticks(4); settle();
        chk("R6 escalation reset", ev_esc, 1);
        chk("R6 no second interrupt", ev_ci, 1);

        // R10: acknowledge clears pending
        @(negedge clk); ci_ack = 1'b1;
        @(negedge clk); ci_ack = 1'b0;
        settle();
        chk("R10 ack clears pending", int'(ci_pend), 0);

        // R4 / R8 / R7: Window mode, P=8, open from count 4
        @(negedge clk); pwr_mode = 3'd2; period = 16'd8;
        idle(2);
        ticks(5); do_kick(); settle();
        chk("R4 open-half kick accepted", ev_early + ev_late, 0);
        ticks(2); do_kick(); settle();
        chk("R8 early kick resets", ev_early, 1);
        ticks(8); settle();
        chk("R7 late overflow resets", ev_late, 1);

        // R9: transition restarts count mid-period
        @(negedge clk); pwr_mode = 3'd1; period = 16'd4;
        idle(2);
        c0 = ev_ci;
        ticks(3);
        @(negedge clk); mode_ctl = 1'b0;
        @(negedge clk); mode_ctl = 1'b1;
        idle(2);
        ticks(3); settle();
        chk("R9 restart after transition", ev_ci - c0, 0);
        ticks(1); settle();
        chk("R9 overflow after full period", ev_ci - c0, 1);
        @(negedge clk); ci_ack = 1'b1;
        @(negedge clk); ci_ack = 1'b0;

        // R11: period 1 acts as 2 (open from count 1)
        @(negedge clk); pwr_mode = 3'd2; period = 16'd1;
        idle(2);
        c0 = ev_early;
        do_kick(); settle();
        chk("R11 kick at count 0 early", ev_early - c0, 1);
        c0 = ev_late;
        ticks(1); do_kick(); settle();
        chk("R11 kick at count 1 accepted", ev_early + ev_late, 2 + 0 + (ev_late - c0) * 0 + 1);
        ticks(2); settle();
        chk("R11 overflow after two ticks", ev_late - c0, 1);

        settle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule